// File: doc/BRIEF.md
# Shadow Register Write-Back Controller

This block holds a bank of fast shadow registers, each backed by a copy in slow persistent storage. Software writes a shadow register through a simple write port. The write marks that register as pending. A small controller then copies pending registers to storage one at a time, without any further software action. Storage is reached through a request/acknowledge handshake whose latency can be long.

A per-register pending vector reports which registers still have a copy outstanding. A register counts as outstanding while it waits and while its copy is in flight. Software polls this vector until it reads zero before it removes power. When several registers are waiting, the lowest index goes first. A register that is written again while its own copy is in flight is queued once more, so its newest value also reaches storage.

The controller has two states. In `CP_IDLE`, the transition *launch* fires when any register is queued. It selects the lowest queued index, captures that register's value, clears its queued mark and moves to `CP_COPY`. In `CP_COPY` the request is driven with steady address and data. The transition *complete* fires on acknowledge and returns to `CP_IDLE`.

Top module: `persist_copy_ctrl`

## Requirements
- R1: After reset, `pending` is all zero and `mst_req` is low.
- R2: A write with `wr_en` high stores `wr_data` into shadow register `wr_idx`. It sets bit `wr_idx` of `pending` (bit i stands for register i) from the next cycle on.
- R3: Each pending register is copied without further input. `mst_req` rises with `mst_addr` equal to the register index and `mst_data` equal to the value written.
- R4: Only one request is outstanding at a time. While `mst_req` is high and `mst_ack` is low, `mst_addr` and `mst_data` do not change. After an acknowledged cycle, `mst_req` is low for at least one cycle.
- R5: When several registers are queued at a launch, the lowest index is copied first. The result is ascending order.
- R6: A register's pending bit clears one cycle after the acknowledge of its copy, unless the register was written again. `pending` returns to zero once all copies are done.
- R7: If a register is rewritten while its copy is in flight, its pending bit stays set. The in-flight data is unchanged, and a second copy with the newest value follows.
- R8: `mst_ack` has no effect while `mst_req` is low. It neither clears a pending bit nor cancels the next launch.
- R9: Several writes to one register before its copy launches merge into a single copy that carries the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_idx | input | 3 | Index of the shadow register written |
| wr_data | input | 32 | Value written to the shadow register |
| mst_req | output | 1 | Storage write request, held until acknowledged |
| mst_addr | output | 3 | Register index of the copy in flight |
| mst_data | output | 32 | Value being copied |
| mst_ack | input | 1 | Storage acknowledge, one cycle, ends the copy |
| pending | output | 8 | One bit per register with a copy still outstanding |

## Verification
The bench builds the block with its defaults: eight registers of 32 bits. It therefore covers the full index range, including both the lowest and highest register as copy targets. Its storage model acknowledges after a delay that is set per test, from zero extra cycles up to twenty. Short delays exercise back-to-back launches. Long delays leave room to rewrite a register while its own copy is in flight, and to queue several others behind it so that the ascending order becomes visible.

// File: rtl/pcopy_pkg.sv
package pcopy_pkg;
    typedef enum logic [0:0] {
        CP_IDLE = 1'b0,
        CP_COPY = 1'b1
    } cp_state_e;
endpackage

// File: rtl/pcopy_shadow_bank.sv
module pcopy_shadow_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              launch,
    input  logic [IDX_W-1:0]  launch_idx,
    output logic [NUM_REGS-1:0] queued,
    output logic [DATA_W-1:0] launch_data
);
    logic [DATA_W-1:0] shadow [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit_wr;
        logic hit_launch;
        assign hit_wr     = wr_en && (wr_idx == IDX_W'(g));
        assign hit_launch = launch && (launch_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[g] <= '0;
                queued[g] <= 1'b0;
            end else begin
                if (hit_wr) begin
                    shadow[g] <= wr_data;
                    queued[g] <= 1'b1;
                end else if (hit_launch) begin
                    queued[g] <= 1'b0;
                end
            end
        end
    end

    assign launch_data = shadow[launch_idx];

    AST_LAUNCH_WAS_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> queued[launch_idx]); // R3
endmodule

// File: rtl/pcopy_pick_lowest.sv
module pcopy_pick_lowest #(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] req,
    output logic                any,
    output logic [IDX_W-1:0]    idx
);
    always_comb begin
        idx = '0;
        for (int i = NUM_REGS - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/pcopy_fsm.sv
module pcopy_fsm
    import pcopy_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                any_queued,
    input  logic [IDX_W-1:0]    pick_idx,
    input  logic [DATA_W-1:0]   pick_data,
    input  logic                mst_ack,
    output logic                launch,
    output logic                mst_req,
    output logic [IDX_W-1:0]    mst_addr,
    output logic [DATA_W-1:0]   mst_data,
    output logic [NUM_REGS-1:0] busy_mask
);
    cp_state_e          state, state_nx;
    logic [IDX_W-1:0]   cur_idx;
    logic [DATA_W-1:0]  cur_data;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CP_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx  <= '0;
            cur_data <= '0;
        end else if (launch) begin
            cur_idx  <= pick_idx;
            cur_data <= pick_data;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CP_IDLE: if (any_queued) state_nx = CP_COPY;
            CP_COPY: if (mst_ack)    state_nx = CP_IDLE;
            default: state_nx = CP_IDLE;
        endcase
    end

    always_comb begin
        launch    = (state == CP_IDLE) && any_queued;
        mst_req   = (state == CP_COPY);
        mst_addr  = cur_idx;
        mst_data  = cur_data;
        busy_mask = '0;
        if (mst_req) busy_mask[cur_idx] = 1'b1;
    end

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && !mst_ack) |=> (mst_req && $stable(mst_addr) && $stable(mst_data))); // R4
    AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && mst_ack) |=> !mst_req); // R4
    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_req && !any_queued) |=> !mst_req); // R8
endmodule

// File: rtl/persist_copy_ctrl.sv
module persist_copy_ctrl #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                mst_req,
    output logic [IDX_W-1:0]    mst_addr,
    output logic [DATA_W-1:0]   mst_data,
    input  logic                mst_ack,
    output logic [NUM_REGS-1:0] pending
);
    logic [NUM_REGS-1:0] queued;
    logic [NUM_REGS-1:0] busy_mask;
    logic                any_queued;
    logic [IDX_W-1:0]    pick_idx;
    logic [DATA_W-1:0]   pick_data;
    logic                launch;

    pcopy_shadow_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .launch(launch), .launch_idx(pick_idx),
        .queued(queued), .launch_data(pick_data)
    );

    pcopy_pick_lowest #(.NUM_REGS(NUM_REGS)) u_pick (
        .req(queued), .any(any_queued), .idx(pick_idx)
    );

    pcopy_fsm #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .any_queued(any_queued), .pick_idx(pick_idx), .pick_data(pick_data),
        .mst_ack(mst_ack), .launch(launch),
        .mst_req(mst_req), .mst_addr(mst_addr), .mst_data(mst_data),
        .busy_mask(busy_mask)
    );

    assign pending = queued | busy_mask;

    AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pending[$past(wr_idx)]); // R2
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (($past(queued) & ((NUM_REGS'(1) << mst_addr) - NUM_REGS'(1))) == '0)); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && mst_ack && !queued[mst_addr] && !(wr_en && wr_idx == mst_addr))
        |=> !pending[$past(mst_addr)]); // R6
endmodule

// File: tb/persist_copy_ctrl_test.sv
module persist_copy_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;
    localparam int DW   = 32;
    localparam int IW   = 3;

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
        logic [7:0]    dly;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{idx: 3'd0, data: 32'h0000_0001, dly: 8'd0},
        '{idx: 3'd7, data: 32'hFFFF_FFFF, dly: 8'd1},
        '{idx: 3'd4, data: 32'hA5A5_5A5A, dly: 8'd3},
        '{idx: 3'd1, data: 32'h1234_5678, dly: 8'd0},
        '{idx: 3'd6, data: 32'h8000_0000, dly: 8'd7},
        '{idx: 3'd2, data: 32'h0000_0000, dly: 8'd2},
        '{idx: 3'd5, data: 32'hDEAD_BEEF, dly: 8'd5},
        '{idx: 3'd3, data: 32'hCAFE_F00D, dly: 8'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic mst_req;
    logic [IW-1:0] mst_addr;
    logic [DW-1:0] mst_data;
    logic mst_ack = 1'b0;
    logic [NREG-1:0] pending;

    int compared = 0;
    int mismatched = 0;
    int ack_delay = 0;
    bit model_en = 1'b1;
    int log_n = 0;
    logic [IW-1:0] log_addr [16];
    logic [DW-1:0] log_data [16];
    int hold_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    persist_copy_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mst_req(mst_req), .mst_addr(mst_addr), .mst_data(mst_data),
        .mst_ack(mst_ack), .pending(pending)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Storage model: logs each request, holds it for ack_delay cycles, then acknowledges.
    initial begin
        forever begin
            @(negedge clk);
            if (mst_req && model_en && rst_n) begin
                if (log_n < 16) begin
                    log_addr[log_n] = mst_addr;
                    log_data[log_n] = mst_data;
                end
                log_n++;
                for (int k = 0; k < ack_delay; k++) begin
                    @(negedge clk);
                    if (!mst_req || mst_addr !== log_addr[log_n-1] || mst_data !== log_data[log_n-1])
                        hold_err++;
                end
                mst_ack = 1'b1;
                @(negedge clk);
                mst_ack = 1'b0;
            end
        end
    end

    task automatic do_write(input logic [IW-1:0] idx, input logic [DW-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (pending == '0 && !mst_req) break;
        end
    endtask

    task automatic finish_run();
        chk("R4 hold", 64'(hold_err), 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL R4 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pending", 64'(pending), 64'd0);
        chk("R1 req", 64'(mst_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", 64'(pending), 64'd0);

        // Table walk: single writes, R2 R3 R6
        for (int v = 0; v < 8; v++) begin
            ack_delay = int'(VEC[v].dly);
            log_n = 0;
            do_write(VEC[v].idx, VEC[v].data);
            chk("R2 pending bit", 64'(pending), 64'(NREG'(1) << VEC[v].idx));
            drain();
            chk("R3 count", 64'(log_n), 64'd1);
            chk("R3 addr", 64'(log_addr[0]), 64'(VEC[v].idx));
            chk("R3 data", 64'(log_data[0]), 64'(VEC[v].data));
            chk("R6 pending zero", 64'(pending), 64'd0);
        end

        // R5: ascending order behind an in-flight copy
        ack_delay = 20; log_n = 0;
        do_write(3'd5, 32'h5555_0005);
        do_write(3'd7, 32'h7777_0007);
        do_write(3'd2, 32'h2222_0002);
        do_write(3'd0, 32'h0000_0F00);
        chk("R5 pending set", 64'(pending), 64'h00A5);
        drain();
        chk("R5 count", 64'(log_n), 64'd4);
        chk("R5 first", 64'(log_addr[0]), 64'd5);
        chk("R5 second", 64'(log_addr[1]), 64'd0);
        chk("R5 third", 64'(log_addr[2]), 64'd2);
        chk("R5 fourth", 64'(log_addr[3]), 64'd7);
        chk("R5 data", 64'(log_data[3]), 64'h7777_0007);

        // R7: rewrite during own copy
        ack_delay = 15; log_n = 0;
        do_write(3'd3, 32'hAAAA_0001);
        repeat (3) @(negedge clk);
        do_write(3'd3, 32'hBBBB_0002);
        chk("R7 pending kept", 64'(pending), 64'h0008);
        chk("R7 inflight data", 64'(mst_data), 64'hAAAA_0001);
        chk("R7 inflight addr", 64'(mst_addr), 64'd3);
        drain();
        chk("R7 count", 64'(log_n), 64'd2);
        chk("R7 second addr", 64'(log_addr[1]), 64'd3);
        chk("R7 second data", 64'(log_data[1]), 64'hBBBB_0002);

        // R9: merged writes before launch
        ack_delay = 15; log_n = 0;
        do_write(3'd1, 32'h1111_1111);
        do_write(3'd4, 32'h4444_0001);
        do_write(3'd4, 32'h4444_0002);
        drain();
        chk("R9 count", 64'(log_n), 64'd2);
        chk("R9 addr", 64'(log_addr[1]), 64'd4);
        chk("R9 data", 64'(log_data[1]), 64'h4444_0002);

        // R8: ack while no request is outstanding
        model_en = 1'b0; log_n = 0; ack_delay = 2;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd6; wr_data = 32'h6666_6666; mst_ack = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; mst_ack = 1'b0;
        chk("R8 pending kept", 64'(pending), 64'h0040);
        @(negedge clk);
        chk("R8 launch not cancelled", 64'(mst_req), 64'd1);
        chk("R8 addr", 64'(mst_addr), 64'd6);
        model_en = 1'b1;
        drain();
        chk("R8 copied", 64'(log_n), 64'd1);
        chk("R8 data", 64'(log_data[0]), 64'h6666_6666);
        chk("R6 final zero", 64'(pending), 64'd0);

        finish_run();
    end
endmodule